// File: doc/BRIEF.md
# Dual-Load Data Memory

This block is a small synchronous data memory that sits in the memory stage of a dual-issue in-order pipeline. It accepts up to two loads and one store in each cycle. Load data comes back on a registered output one cycle after the request. Tags, misses and refill are handled elsewhere. The block only holds words.

A parameter picks one of two internal organisations:

- **Replicated.** Two complete copies of the storage are kept. Each load slot reads its own copy, so loads never collide. Every store is written into both copies, which means replication adds read bandwidth only.
- **Banked.** Storage is split by the least significant word-address bit into an even bank and an odd bank. An even/odd load pair completes together. Two loads that land in the same bank are serialised:
  - the stall output rises for that cycle;
  - the slot-0 load is served at once;
  - the slot-1 load is held inside the block and read in the next cycle.
  - The pipeline must not offer new loads in that next cycle; any offered there are dropped.

A load and a store to the same word in the same cycle return the value held before the store.

Top module: `dual_load_dmem`

## Requirements
- R1: Every accepted load returns its word on its own port, with the return-valid flag high, exactly one cycle after the request. In replicated mode both slots are always accepted.
- R2: In replicated mode a store updates both copies, so either load slot reads the stored value afterwards.
- R3: In replicated mode the stall output stays low for every address pair, including two loads of the same word.
- R4: In banked mode, either of these cases completes both loads in one cycle with stall low:
  - a load pair whose word addresses differ in bit 0;
  - a single load on either slot.
- R5: In banked mode, two valid loads with equal address bit 0 raise stall in that cycle only. Slot 0 returns one cycle later. Slot 1 returns two cycles after the request, with the value the word holds after any store made in the request cycle.
- R6: In banked mode, loads offered in the cycle after a conflict are ignored: they produce no return on slot 0, and stall stays low in that cycle.
- R7: A load and a store to the same word in the same cycle return the old data. A later load returns the new data.
- R8: A store offered together with two loads is accepted, and its write is applied to both copies (replicated) or to bank `addr[0]` (banked).
- R9: After reset, both return-valid flags and the stall output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld0_vld | input | 1 | Slot-0 (older) load request |
| ld0_addr | input | ADDR_W | Slot-0 word address |
| ld1_vld | input | 1 | Slot-1 (younger) load request |
| ld1_addr | input | ADDR_W | Slot-1 word address |
| st_vld | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| ld0_rvld | output | 1 | Slot-0 read data valid |
| ld0_rdata | output | DATA_W | Slot-0 read data |
| ld1_rvld | output | 1 | Slot-1 read data valid |
| ld1_rdata | output | DATA_W | Slot-1 read data |
| stall | output | 1 | Bank conflict: slot-1 load deferred by one cycle |

## Verification
The bench drives both organisations side by side with the same stimulus. It sweeps every ordered pair of load addresses:

- Same-parity pairs separate the banked conflict path from the replicated path, which must never stall.
- Equal-address pairs show that the two copies really are independent.
- Single-slot loads confirm that one request alone never raises a conflict.
- Stores to a word being loaded in the same cycle separate read-before-write from write-first.
- Stores to the deferred slot-1 word show that the deferred read takes place one cycle late.
- Loads offered in the cycle after a conflict show that they are dropped.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic {
    ORG_REPLICATED = 1'b0,
    ORG_BANKED     = 1'b1
  } org_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/dlm_bank.sv
module dlm_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // write port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read port samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dlm_steer.sv
module dlm_steer
  import dlm_pkg::*;
#(
  parameter int   ADDR_W  = 6,
  parameter int   BANK_AW = 5,
  parameter org_e ORG     = ORG_BANKED
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld0_vld,
  input  logic [ADDR_W-1:0]       ld0_addr,
  input  logic                    ld1_vld,
  input  logic [ADDR_W-1:0]       ld1_addr,
  output logic [1:0]              rd_en,
  output logic [1:0][BANK_AW-1:0] rd_addr,
  output logic                    srv0,
  output logic                    srv0_bank,
  output logic                    srv1,
  output logic                    srv1_bank,
  output logic                    conflict,
  output logic                    busy
);
  generate
    if (ORG == ORG_REPLICATED) begin : g_rep
      always_comb begin
        rd_en[0]   = ld0_vld;
        rd_addr[0] = ld0_addr;
        rd_en[1]   = ld1_vld;
        rd_addr[1] = ld1_addr;
        srv0       = ld0_vld;
        srv0_bank  = 1'b0;
        srv1       = ld1_vld;
        srv1_bank  = 1'b1;
        conflict   = 1'b0;
        busy       = 1'b0;
      end
    end else begin : g_bnk
      logic              pend_d, pend_q;
      logic [ADDR_W-1:0] pend_addr_q;
      logic              pend_addr_en;
      logic              b0, b1;

      assign b0 = ld0_addr[0];
      assign b1 = ld1_addr[0];

      // next-state / steering
      always_comb begin
        rd_en     = '0;
        rd_addr   = '0;
        srv0      = 1'b0;
        srv0_bank = 1'b0;
        srv1      = 1'b0;
        srv1_bank = 1'b0;
        conflict  = 1'b0;
        if (pend_q) begin
          rd_en[pend_addr_q[0]]   = 1'b1;
          rd_addr[pend_addr_q[0]] = pend_addr_q[ADDR_W-1:1];
          srv1                    = 1'b1;
          srv1_bank               = pend_addr_q[0];
        end else begin
          conflict = ld0_vld && ld1_vld && (b0 == b1);
          if (ld0_vld) begin
            rd_en[b0]   = 1'b1;
            rd_addr[b0] = ld0_addr[ADDR_W-1:1];
            srv0        = 1'b1;
            srv0_bank   = b0;
          end
          if (ld1_vld && !conflict) begin
            rd_en[b1]   = 1'b1;
            rd_addr[b1] = ld1_addr[ADDR_W-1:1];
            srv1        = 1'b1;
            srv1_bank   = b1;
          end
        end
        pend_d       = conflict;
        pend_addr_en = conflict;
        busy         = pend_q;
      end

      // registers
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
      end

      always_ff @(posedge clk) begin
        if (pend_addr_en) pend_addr_q <= ld1_addr;
      end

      // R6: the deferral lasts a single cycle
      p_defer_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q);

      // R4/R5: the two slots are never read from the same bank in one cycle
      p_bank_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (srv0 && srv1) |-> (srv0_bank != srv1_bank));
    end
  endgenerate
endmodule

// File: rtl/dlm_return.sv
module dlm_return #(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   srv0,
  input  logic                   srv0_bank,
  input  logic                   srv1,
  input  logic                   srv1_bank,
  input  logic [1:0][DATA_W-1:0] bank_rdata,
  output logic                   ld0_rvld,
  output logic [DATA_W-1:0]      ld0_rdata,
  output logic                   ld1_rvld,
  output logic [DATA_W-1:0]      ld1_rdata
);
  logic v0_q, v1_q;
  logic sel0_q, sel1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0_q <= 1'b0;
      v1_q <= 1'b0;
    end else begin
      v0_q <= srv0;
      v1_q <= srv1;
    end
  end

  always_ff @(posedge clk) begin
    if (srv0) sel0_q <= srv0_bank;
    if (srv1) sel1_q <= srv1_bank;
  end

  assign ld0_rvld  = v0_q;
  assign ld1_rvld  = v1_q;
  assign ld0_rdata = bank_rdata[sel0_q];
  assign ld1_rdata = bank_rdata[sel1_q];
endmodule

// File: rtl/dual_load_dmem.sv
module dual_load_dmem
  import dlm_pkg::*;
#(
  parameter int   DATA_W = 32,
  parameter int   ADDR_W = 6,
  parameter org_e ORG    = ORG_BANKED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld0_vld,
  input  logic [ADDR_W-1:0] ld0_addr,
  input  logic              ld1_vld,
  input  logic [ADDR_W-1:0] ld1_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              ld0_rvld,
  output logic [DATA_W-1:0] ld0_rdata,
  output logic              ld1_rvld,
  output logic [DATA_W-1:0] ld1_rdata,
  output logic              stall
);
  localparam int BANK_AW = (ORG == ORG_BANKED) ? ADDR_W - 1 : ADDR_W;

  logic [1:0]              rd_en;
  logic [1:0][BANK_AW-1:0] rd_addr;
  logic [1:0]              wr_en;
  logic [1:0][BANK_AW-1:0] wr_addr;
  logic [1:0][DATA_W-1:0]  bank_rdata;
  logic                    srv0, srv0_bank, srv1, srv1_bank;
  logic                    conflict, busy;

  dlm_steer #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .ORG(ORG)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld0_vld  (ld0_vld),
    .ld0_addr (ld0_addr),
    .ld1_vld  (ld1_vld),
    .ld1_addr (ld1_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .srv0     (srv0),
    .srv0_bank(srv0_bank),
    .srv1     (srv1),
    .srv1_bank(srv1_bank),
    .conflict (conflict),
    .busy     (busy)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (ORG == ORG_REPLICATED) begin : g_wr_rep
        // store broadcast to every copy
        assign wr_en[b]   = st_vld;
        assign wr_addr[b] = st_addr;
      end else begin : g_wr_bnk
        // store goes to the bank named by address bit 0
        assign wr_en[b]   = st_vld && (st_addr[0] == 1'(b));
        assign wr_addr[b] = st_addr[ADDR_W-1:1];
      end

      dlm_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
        .clk    (clk),
        .rd_en  (rd_en[b]),
        .rd_addr(rd_addr[b]),
        .wr_en  (wr_en[b]),
        .wr_addr(wr_addr[b]),
        .wr_data(st_data),
        .rd_data(bank_rdata[b])
      );
    end
  endgenerate

  dlm_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .srv0      (srv0),
    .srv0_bank (srv0_bank),
    .srv1      (srv1),
    .srv1_bank (srv1_bank),
    .bank_rdata(bank_rdata),
    .ld0_rvld  (ld0_rvld),
    .ld0_rdata (ld0_rdata),
    .ld1_rvld  (ld1_rvld),
    .ld1_rdata (ld1_rdata)
  );

  assign stall = conflict;

  // R1: a slot-0 load not blocked by a pending deferral returns next cycle
  p_ld0_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld0_vld && !busy) |=> ld0_rvld);

  // R9: no slot-0 return without a request the cycle before
  p_ld0_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld0_vld |=> !ld0_rvld);

  // R5: a stall lasts one cycle and the deferred slot-1 load returns two cycles later
  p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  p_deferred_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ##2 ld1_rvld);

  generate
    if (ORG == ORG_REPLICATED) begin : g_chk_rep
      // R3: both loads always return together
      p_both_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld0_vld && ld1_vld) |=> (ld0_rvld && ld1_rvld));
    end
  endgenerate
endmodule

// File: tb/test_dual_load_dmem.sv
`timescale 1ns/1ps
module test_dual_load_dmem;
  import dlm_pkg::*;

  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          ld0_vld, ld1_vld, st_vld;
  logic [AW-1:0] ld0_addr, ld1_addr, st_addr;
  logic [DW-1:0] st_data;

  logic          r_ld0_rvld, r_ld1_rvld, r_stall;
  logic [DW-1:0] r_ld0_rdata, r_ld1_rdata;
  logic          b_ld0_rvld, b_ld1_rvld, b_stall;
  logic [DW-1:0] b_ld0_rdata, b_ld1_rdata;

  dual_load_dmem #(.DATA_W(DW), .ADDR_W(AW), .ORG(ORG_REPLICATED)) i_dual_load_dmem (
    .clk(clk), .rst_n(rst_n),
    .ld0_vld(ld0_vld), .ld0_addr(ld0_addr), .ld1_vld(ld1_vld), .ld1_addr(ld1_addr),
    .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
    .ld0_rvld(r_ld0_rvld), .ld0_rdata(r_ld0_rdata),
    .ld1_rvld(r_ld1_rvld), .ld1_rdata(r_ld1_rdata), .stall(r_stall)
  );

  dual_load_dmem #(.DATA_W(DW), .ADDR_W(AW), .ORG(ORG_BANKED)) i_dual_load_dmem_bk (
    .clk(clk), .rst_n(rst_n),
    .ld0_vld(ld0_vld), .ld0_addr(ld0_addr), .ld1_vld(ld1_vld), .ld1_addr(ld1_addr),
    .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
    .ld0_rvld(b_ld0_rvld), .ld0_rdata(b_ld0_rdata),
    .ld1_rvld(b_ld1_rvld), .ld1_rdata(b_ld1_rdata), .stall(b_stall)
  );

  int            checks = 0;
  int            errors = 0;
  logic [DW-1:0] model [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_val(input int a, input int salt);
    return DW'(32'h5A00_0000 ^ (a * 32'h0001_0203) ^ (salt * 32'h1111_0000));
  endfunction

  task automatic drive_idle();
    ld0_vld = 1'b0; ld1_vld = 1'b0; st_vld = 1'b0;
    ld0_addr = '0;  ld1_addr = '0;  st_addr = '0; st_data = '0;
  endtask

  // one request cycle; returns checked on both organisations
  task automatic step(input bit v0, input int a0, input bit v1, input int a1,
                      input bit sv, input int sa, input logic [DW-1:0] sd,
                      input bit iv, input int ia);
    bit            conf;
    logic          rs, bs;
    logic [DW-1:0] e0, e1_old, e1_new, ei;
    @(negedge clk);
    ld0_vld = v0; ld0_addr = AW'(a0);
    ld1_vld = v1; ld1_addr = AW'(a1);
    st_vld = sv;  st_addr = AW'(sa); st_data = sd;
    #1;
    rs = r_stall; bs = b_stall;
    conf   = v0 && v1 && (a0[0] == a1[0]);
    e0     = model[a0];
    e1_old = model[a1];
    if (sv) model[sa] = sd;
    e1_new = model[a1];
    chk(rs == 1'b0, "R3 replicated stall", DW'(rs), '0);
    chk(bs == conf, conf ? "R5 banked stall" : "R4 banked stall", DW'(bs), DW'(conf));
    @(negedge clk);
    // replicated
    chk(r_ld0_rvld == v0, "R1 rep ld0_rvld", DW'(r_ld0_rvld), DW'(v0));
    chk(r_ld1_rvld == v1, "R1 rep ld1_rvld", DW'(r_ld1_rvld), DW'(v1));
    if (v0) chk(r_ld0_rdata == e0, "R7 rep ld0 data", r_ld0_rdata, e0);
    if (v1) chk(r_ld1_rdata == e1_old, "R2 rep ld1 data", r_ld1_rdata, e1_old);
    // banked
    chk(b_ld0_rvld == v0, "R4 bank ld0_rvld", DW'(b_ld0_rvld), DW'(v0));
    chk(b_ld1_rvld == (v1 && !conf), "R5 bank ld1_rvld", DW'(b_ld1_rvld), DW'(v1 && !conf));
    if (v0) chk(b_ld0_rdata == e0, "R4 bank ld0 data", b_ld0_rdata, e0);
    if (v1 && !conf) chk(b_ld1_rdata == e1_old, "R4 bank ld1 data", b_ld1_rdata, e1_old);
    drive_idle();
    if (conf) begin
      // loads offered now must be dropped by the banked block
      ld0_vld = iv; ld0_addr = AW'(ia);
      ld1_vld = iv; ld1_addr = AW'(ia);
      ei = model[ia];
      #1;
      chk(b_stall == 1'b0, "R6 bank stall after conflict", DW'(b_stall), '0);
      @(negedge clk);
      chk(b_ld1_rvld == 1'b1, "R5 bank deferred rvld", DW'(b_ld1_rvld), 1);
      chk(b_ld1_rdata == e1_new, "R5 bank deferred data", b_ld1_rdata, e1_new);
      chk(b_ld0_rvld == 1'b0, "R6 bank ignored ld0", DW'(b_ld0_rvld), '0);
      chk(r_ld0_rvld == iv, "R1 rep ld0_rvld second", DW'(r_ld0_rvld), DW'(iv));
      if (iv) chk(r_ld0_rdata == ei, "R1 rep ld0 data second", r_ld0_rdata, ei);
      drive_idle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(!r_ld0_rvld && !r_ld1_rvld && !r_stall, "R9 rep reset state",
        DW'({r_ld0_rvld, r_ld1_rvld, r_stall}), '0);
    chk(!b_ld0_rvld && !b_ld1_rvld && !b_stall, "R9 bank reset state",
        DW'({b_ld0_rvld, b_ld1_rvld, b_stall}), '0);

    // fill every word (R2: both copies written)
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 0, 1, a, word_val(a, 0), 0, 0);

    // single-slot loads (R4)
    for (int a = 0; a < DEPTH; a++) begin
      step(1, a, 0, 0, 0, 0, '0, 0, 0);
      step(0, 0, 1, a, 0, 0, '0, 0, 0);
    end

    // every ordered address pair (R1 R3 R4 R5), ignored loads on conflicts (R6)
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        step(1, i, 1, j, 0, 0, '0, 1, (i + 3) % DEPTH);

    // read-before-write on the same word, then new value visible (R7)
    for (int k = 0; k < DEPTH; k++) begin
      step(1, k, 0, 0, 1, k, word_val(k, 2), 0, 0);
      step(1, k, 1, k ^ 1, 0, 0, '0, 0, 0);
    end

    // store alongside two loads; store hits the deferred word (R8 R5)
    for (int k = 0; k < DEPTH; k++) begin
      step(1, k, 1, (k + 2) % DEPTH, 1, (k + 2) % DEPTH, word_val(k, 3), 0, 0);
    end

    // store alongside an even/odd pair, read back from both slots (R8 R2)
    for (int k = 0; k < DEPTH; k++) begin
      step(1, (k + 1) % DEPTH, 1, (k + 4) % DEPTH, 1, k, word_val(k, 4), 0, 0);
      step(1, k, 1, k, 0, 0, '0, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule